// File: doc/BRIEF.md
# Oscillator Trim Calibrator

This controller searches for the trim code that brings a tunable oscillator closest to a requested frequency. Software or a boot sequencer supplies the wanted frequency in MHz and pulses a start strobe. The block turns that frequency into an expected meter count. It drives trial codes onto the oscillator's trim input. After every code change it waits a settle interval, then asks an external frequency meter for a count.

It first measures with the code it already holds. When that reading is inside a ±4% window, it keeps the code and finishes. Otherwise it runs a successive-approximation search over the full trim field. It then measures both final bounds, keeps the one with the smaller error and measures that code once more. It reports done together with a fail flag that stays set until the next start.

The meter count is taken to be the oscillator frequency in units of 26/1024 MHz. The settle interval is a parameter given in reference-clock cycles.

Top module: `osc_trim_cal`

## Requirements
- R1: While and after reset, `trim_o` holds the default code 31, and `done_o`, `fail_o` and `meas_start_o` are low.
- R2: The expected count is floor(MHz × 1024 / 26). A reading counts as accurate only when it is strictly greater than floor(expected × 960 / 1000) and strictly less than floor(expected × 1040 / 1000).
- R3: The first measurement after a start uses the code already on `trim_o`. If that reading is accurate, the block finishes with that code, with `fail_o` low, after exactly one measurement.
- R4: Otherwise the search starts with low = 0 and high = 63. It tries mid = floor((low + high) / 2) and stops once mid equals low. A reading above the expected count sets high = mid; any other reading sets low = mid.
- R5: After the search, the block measures at low and then at high. It keeps low only when its absolute error is strictly smaller; on a tie it keeps high.
- R6: The kept code is written and measured once more. `done_o` rises, with `fail_o` high exactly when that reading is not accurate. Both outputs and `trim_o` hold until the next start.
- R7: No measurement is requested until at least SETTLE_CYC cycles after the last change of `trim_o`. `trim_o` does not change while a measurement is outstanding.
- R8: `meas_start_o` is a one-cycle pulse. At most one measurement is outstanding, ended by a `meas_done_i` pulse that carries the count on `meas_cnt_i`.
- R9: A start pulse while a calibration is running is ignored. The requested frequency is captured only at an accepted start.
- R10: An accepted start clears `done_o` and `fail_o` on the next cycle. `meas_start_o` is never high while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start calibration strobe, accepted when idle |
| target_mhz_i | input | MHZ_W | Requested frequency in MHz, captured at start |
| meas_cnt_i | input | CNT_W | Meter count, valid with `meas_done_i` |
| meas_done_i | input | 1 | Meter result strobe |
| trim_o | output | TRIM_W | Trim code driven to the oscillator |
| meas_start_o | output | 1 | Meter start request pulse |
| done_o | output | 1 | Calibration finished |
| fail_o | output | 1 | Final verification missed the tolerance window |

## Verification
The checks assume the meter behaves as R8 describes: it answers each request with exactly one `meas_done_i` pulse, it never answers without a request, and `meas_cnt_i` matters only in the cycle of that pulse. The bench meter model answers three cycles after each request with a count from a linear oscillator model of the trim code held at that moment, and it never raises `meas_done_i` on its own. Because the oscillator models are monotonic, the search reaches the bounds R4 describes. Start pulses during a run are given only where R9 says they must be ignored.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_WAIT,
    ST_STEP
  } cal_state_e;

  typedef enum logic [2:0] {
    PH_PRE,
    PH_SEARCH,
    PH_FIN_LO,
    PH_FIN_HI,
    PH_VERIFY
  } cal_phase_e;

  // meter count = MHz * SCALE_NUM / SCALE_DEN
  localparam int unsigned SCALE_NUM  = 1024;
  localparam int unsigned SCALE_DEN  = 26;
  // tolerance window in per-mille of the expected count
  localparam int unsigned WIN_LO_PM  = 960;
  localparam int unsigned WIN_HI_PM  = 1040;
  localparam int unsigned PERMIL     = 1000;

endpackage

// File: rtl/otc_target.sv
// Captures the expected count and window bounds at start; compares readings.
module otc_target
  import osc_trim_pkg::*;
#(
  parameter int MHZ_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [MHZ_W-1:0] mhz_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             above_o,
  output logic             in_win_o,
  output logic [CNT_W-1:0] err_o
);

  localparam int WIN_W = CNT_W + 1;

  function automatic logic [CNT_W-1:0] f_expect(input logic [MHZ_W-1:0] m);
    return CNT_W'((32'(m) * 32'(SCALE_NUM)) / 32'(SCALE_DEN));
  endfunction

  function automatic logic [WIN_W-1:0] f_bound(input logic [CNT_W-1:0] t,
                                               input int unsigned pm);
    return WIN_W'((32'(t) * 32'(pm)) / 32'(PERMIL));
  endfunction

  logic [CNT_W-1:0] tgt_n, tgt_q;
  logic [WIN_W-1:0] wlo_q, whi_q;
  logic [WIN_W-1:0] cnt_x;

  assign tgt_n = f_expect(mhz_i);
  assign cnt_x = {1'b0, cnt_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= '0;
      wlo_q <= '0;
      whi_q <= '0;
    end else if (load_i) begin
      tgt_q <= tgt_n;
      wlo_q <= f_bound(tgt_n, WIN_LO_PM);
      whi_q <= f_bound(tgt_n, WIN_HI_PM);
    end
  end

  assign above_o  = cnt_i > tgt_q;
  assign in_win_o = (cnt_x > wlo_q) && (cnt_x < whi_q);
  assign err_o    = above_o ? (cnt_i - tgt_q) : (tgt_q - cnt_i);

endmodule

// File: rtl/otc_settle_timer.sv
// Down-counter loaded on every trim change; expired once it reaches zero.
module otc_settle_timer #(
  parameter int SETTLE_CYC = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic expired_o
);

  localparam int TW = $clog2(SETTLE_CYC + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= TW'(SETTLE_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/otc_search.sv
// Holds the search bounds and derives the next trial code.
module otc_search #(
  parameter int TRIM_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              upd_i,
  input  logic              above_i,
  output logic [TRIM_W-1:0] lo_o,
  output logic [TRIM_W-1:0] hi_o,
  output logic [TRIM_W-1:0] mid_o,
  output logic              conv_o
);

  logic [TRIM_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '1;
    end else if (init_i) begin
      lo_q <= '0;
      hi_q <= '1;
    end else if (upd_i) begin
      if (above_i) hi_q <= mid_o;
      else         lo_q <= mid_o;
    end
  end

  assign mid_o  = TRIM_W'(({1'b0, lo_q} + {1'b0, hi_q}) >> 1);
  assign conv_o = (mid_o == lo_q);
  assign lo_o   = lo_q;
  assign hi_o   = hi_q;

endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal
  import osc_trim_pkg::*;
#(
  parameter int TRIM_W       = 6,
  parameter int CNT_W        = 16,
  parameter int MHZ_W        = 8,
  parameter int SETTLE_CYC   = 2500,
  parameter int DEFAULT_TRIM = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MHZ_W-1:0]  target_mhz_i,
  input  logic [CNT_W-1:0]  meas_cnt_i,
  input  logic              meas_done_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              meas_start_o,
  output logic              done_o,
  output logic              fail_o
);

  cal_state_e        state_q, state_d;
  cal_phase_e        phase_q, phase_d;
  logic [TRIM_W-1:0] trim_q, trim_d;
  logic [CNT_W-1:0]  errlo_q, errlo_d;
  logic              ms_q, ms_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;

  logic              tgt_load, tmr_load, tmr_exp;
  logic              s_init, s_upd;
  logic              above, in_win;
  logic [CNT_W-1:0]  abs_err;
  logic [TRIM_W-1:0] s_lo, s_hi, s_mid;
  logic              s_conv;

  otc_target #(.MHZ_W(MHZ_W), .CNT_W(CNT_W)) u_target (
    .clk      (clk),
    .rst      (rst),
    .load_i   (tgt_load),
    .mhz_i    (target_mhz_i),
    .cnt_i    (meas_cnt_i),
    .above_o  (above),
    .in_win_o (in_win),
    .err_o    (abs_err)
  );

  otc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .expired_o (tmr_exp)
  );

  otc_search #(.TRIM_W(TRIM_W)) u_search (
    .clk     (clk),
    .rst     (rst),
    .init_i  (s_init),
    .upd_i   (s_upd),
    .above_i (above),
    .lo_o    (s_lo),
    .hi_o    (s_hi),
    .mid_o   (s_mid),
    .conv_o  (s_conv)
  );

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    trim_d   = trim_q;
    errlo_d  = errlo_q;
    ms_d     = 1'b0;
    done_d   = done_q;
    fail_d   = fail_q;
    tgt_load = 1'b0;
    tmr_load = 1'b0;
    s_init   = 1'b0;
    s_upd    = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          done_d   = 1'b0;
          fail_d   = 1'b0;
          tgt_load = 1'b1;
          tmr_load = 1'b1;
          phase_d  = PH_PRE;
          state_d  = ST_SETTLE;
        end
      end

      ST_SETTLE: begin
        if (tmr_exp) begin
          ms_d    = 1'b1;
          state_d = ST_WAIT;
        end
      end

      ST_WAIT: begin
        if (meas_done_i) begin
          unique case (phase_q)
            PH_PRE: begin
              if (in_win) begin
                done_d  = 1'b1;
                state_d = ST_IDLE;
              end else begin
                s_init  = 1'b1;
                state_d = ST_STEP;
              end
            end
            PH_SEARCH: begin
              s_upd   = 1'b1;
              state_d = ST_STEP;
            end
            PH_FIN_LO: begin
              errlo_d  = abs_err;
              trim_d   = s_hi;
              phase_d  = PH_FIN_HI;
              tmr_load = 1'b1;
              state_d  = ST_SETTLE;
            end
            PH_FIN_HI: begin
              trim_d   = (errlo_q < abs_err) ? s_lo : s_hi;
              phase_d  = PH_VERIFY;
              tmr_load = 1'b1;
              state_d  = ST_SETTLE;
            end
            default: begin
              done_d  = 1'b1;
              fail_d  = ~in_win;
              state_d = ST_IDLE;
            end
          endcase
        end
      end

      default: begin
        if (s_conv) begin
          trim_d  = s_lo;
          phase_d = PH_FIN_LO;
        end else begin
          trim_d  = s_mid;
          phase_d = PH_SEARCH;
        end
        tmr_load = 1'b1;
        state_d  = ST_SETTLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= PH_PRE;
      trim_q  <= TRIM_W'(DEFAULT_TRIM);
      errlo_q <= '0;
      ms_q    <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      trim_q  <= trim_d;
      errlo_q <= errlo_d;
      ms_q    <= ms_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign trim_o       = trim_q;
  assign meas_start_o = ms_q;
  assign done_o       = done_q;
  assign fail_o       = fail_q;

endmodule

// File: rtl/otc_checker.sv
module otc_checker #(
  parameter int TRIM_W     = 6,
  parameter int SETTLE_CYC = 2500
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              meas_done_i,
  input logic [TRIM_W-1:0] trim_o,
  input logic              meas_start_o,
  input logic              done_o,
  input logic              fail_o
);

  logic              outst_q;
  logic [31:0]       age_q;
  logic [TRIM_W-1:0] trim_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      outst_q     <= 1'b0;
      age_q       <= '0;
      trim_prev_q <= trim_o;
    end else begin
      if (meas_start_o)     outst_q <= 1'b1;
      else if (meas_done_i) outst_q <= 1'b0;
      trim_prev_q <= trim_o;
      if (trim_o != trim_prev_q)  age_q <= '0;
      else if (age_q != '1)       age_q <= age_q + 32'd1;
    end
  end

  AST_MEAS_PULSE: assert property (@(posedge clk) disable iff (rst)
    meas_start_o |=> !meas_start_o); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    meas_start_o |-> !outst_q); // R8
  AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (rst)
    meas_start_o |-> (age_q >= 32'(SETTLE_CYC))); // R7
  AST_TRIM_HELD: assert property (@(posedge clk) disable iff (rst)
    outst_q |-> $stable(trim_o)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(trim_o) && $stable(fail_o))); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !meas_start_o); // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (done_o && start_i) |=> (!done_o && !fail_o)); // R10

endmodule

bind osc_trim_cal otc_checker #(
  .TRIM_W     (TRIM_W),
  .SETTLE_CYC (SETTLE_CYC)
) u_otc_checker (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .meas_done_i  (meas_done_i),
  .trim_o       (trim_o),
  .meas_start_o (meas_start_o),
  .done_o       (done_o),
  .fail_o       (fail_o)
);

// File: tb/test_osc_trim_cal.sv
`timescale 1ns/1ps
module test_osc_trim_cal;

  localparam int TW  = 6;
  localparam int CW  = 16;
  localparam int MW  = 8;
  localparam int SET = 4;
  localparam int DEF = 31;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_i;
  logic [MW-1:0] target_mhz_i;
  logic [CW-1:0] meas_cnt_i;
  logic          meas_done_i;
  logic [TW-1:0] trim_o;
  logic          meas_start_o;
  logic          done_o;
  logic          fail_o;

  int checks = 0;
  int fails  = 0;
  int m_base = 200;
  int m_slope = 6;
  int nmeas = 0;
  int age = 0;
  int prev_trim = DEF;

  osc_trim_cal #(
    .TRIM_W(TW), .CNT_W(CW), .MHZ_W(MW), .SETTLE_CYC(SET), .DEFAULT_TRIM(DEF)
  ) i_osc_trim_cal (
    .clk(clk), .rst(rst), .start_i(start_i), .target_mhz_i(target_mhz_i),
    .meas_cnt_i(meas_cnt_i), .meas_done_i(meas_done_i), .trim_o(trim_o),
    .meas_start_o(meas_start_o), .done_o(done_o), .fail_o(fail_o)
  );

  always #10 clk = ~clk;

  function automatic int osc(input int code);
    return m_base + m_slope * code;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Model of the requirements: final code, fail flag, measurement count
  task automatic ref_cal(input int mhz, input int cur, output int fin,
                         output bit fl, output int nm, output bit pre);
    int t, wl, wh, c, lo, hi, mid, el, eh;
    t  = mhz * 1024 / 26;
    wl = t * 960 / 1000;
    wh = t * 1040 / 1000;
    nm = 1;
    c  = osc(cur);
    pre = (c > wl) && (c < wh);
    if (pre) begin
      fin = cur; fl = 1'b0;
      return;
    end
    lo = 0; hi = 63;
    forever begin
      mid = (lo + hi) / 2;
      if (mid == lo) break;
      nm++;
      if (osc(mid) > t) hi = mid; else lo = mid;
    end
    el = (osc(lo) > t) ? osc(lo) - t : t - osc(lo);
    eh = (osc(hi) > t) ? osc(hi) - t : t - osc(hi);
    fin = (el < eh) ? lo : hi;
    nm += 3;
    c  = osc(fin);
    fl = !((c > wl) && (c < wh));
  endtask

  task automatic tick();
    @(negedge clk);
    if (int'(trim_o) != prev_trim) age = 0; else age++;
    prev_trim = int'(trim_o);
  endtask

  // Frequency meter model: answers three cycles after each request
  initial begin
    int held;
    meas_done_i = 1'b0;
    meas_cnt_i  = '0;
    forever begin
      tick();
      if (!rst && meas_start_o) begin
        nmeas++;
        check(age >= SET, "R7 settle before request", age, SET);
        held = int'(trim_o);
        tick();
        check(!meas_start_o, "R8 request pulse width", int'(meas_start_o), 0);
        tick();
        tick();
        check(int'(trim_o) == held, "R7 trim held while measuring", int'(trim_o), held);
        meas_cnt_i  = CW'(osc(held));
        meas_done_i = 1'b1;
        tick();
        meas_done_i = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic run(input int mhz, input bit disturb, inout int cur);
    int  efin, enm;
    bit  efl, epre;
    ref_cal(mhz, cur, efin, efl, enm, epre);
    nmeas = 0;
    target_mhz_i = MW'(mhz);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(!done_o && !fail_o, "R10 start clears done", int'(done_o), 0);
    if (disturb) begin
      repeat (5) @(negedge clk);
      target_mhz_i = MW'(mhz + 7);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    if (disturb)
      check(int'(trim_o) == efin, "R9 start ignored while busy, trim", int'(trim_o), efin);
    else if (epre)
      check(int'(trim_o) == efin, "R3 pre-check keeps code", int'(trim_o), efin);
    else
      check(int'(trim_o) == efin, "R4 R5 searched trim", int'(trim_o), efin);
    check(fail_o == efl, "R2 R6 fail flag", int'(fail_o), int'(efl));
    check(nmeas == enm, epre ? "R3 measurement count" : "R4 R5 R6 measurement count",
          nmeas, enm);
    repeat (3) @(negedge clk);
    check(done_o && int'(trim_o) == efin && fail_o == efl, "R6 result held",
          int'(trim_o), efin);
    cur = efin;
  endtask

  initial begin
    int cur;
    rst = 1'b1;
    start_i = 1'b0;
    target_mhz_i = '0;
    repeat (3) @(negedge clk);
    check(int'(trim_o) == DEF, "R1 reset trim", int'(trim_o), DEF);
    check(!done_o && !fail_o && !meas_start_o, "R1 reset flags",
          int'({done_o, fail_o, meas_start_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(int'(trim_o) == DEF && !done_o, "R1 after reset", int'(trim_o), DEF);
    cur = DEF;
    for (int m = 0; m < 4; m++) begin
      case (m)
        0: begin m_base = 200; m_slope = 6;  end
        1: begin m_base = 50;  m_slope = 12; end
        2: begin m_base = 300; m_slope = 2;  end
        default: begin m_base = 380; m_slope = 1; end
      endcase
      for (int mhz = 5; mhz <= 40; mhz++) begin
        run(mhz, (mhz % 5) == 0, cur);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule